// File: doc/BRIEF.md
# Interrupt exception entry controller

This block decides, once per instruction, whether the processor enters a fast or a normal interrupt handler. It also works out the status word the handler starts with. The two active-low request lines first pass through one register stage inside the block. When the pipeline raises its instruction-boundary strobe, the block weighs the registered requests against the mask flags in the current status word and against three secure-configuration bits, then selects at most one exception.

In the cycle after that decision the block emits a one-cycle take pulse and a two-bit exception code. With them it presents:
- the new status word (mode, masks, state bits);
- the old status word, for the target mode's saved-status register;
- a link value equal to the next instruction address plus four;
- a vector offset, with a flag that selects the monitor vector table;
- the world bit the core must adopt.

On the first clock after reset is released, the block presents the fixed reset state instead. That entry wins over any interrupt in the same cycle.

Status word bit positions used on `cpsr_in` and `cpsr_out`:

| Field | Bits |
|---|---|
| Mode | [4:0] |
| T | 5 |
| F | 6 |
| I | 7 |
| A | 8 |
| E | 9 |
| J | 24 |

Top module: `irq_entry_ctrl`

## Requirements
- R1: Each request line is registered once, and the decision uses only the registered value. A line that first goes low in the same cycle as the boundary strobe is not taken at that boundary.
- R2: An interrupt is taken only at a clock edge where `boundary` is high. The registered line must be low and its mask must be clear (F for fast, I for normal). Otherwise `take` stays 0.
- R3: When both requests are valid at one boundary, only the fast one is taken (code 2'b10). The normal one stays pending.
- R4: On entry, T and J are cleared, I is set, and F is also set for a fast entry. Every other bit of `cpsr_in` except the mode field passes unchanged to `cpsr_out`.
- R5: When `ns_in` and `cfg_fw` are both 1, the fast request ignores F. In every other case F masks it.
- R6: The new mode is 5'b10001 for fast and 5'b10010 for normal. When `cfg_fiq_mon` (for fast) or `cfg_irq_mon` (for normal) is 1, the mode is 5'b10110 instead and `vec_mon` is 1.
- R7: On the first clock after reset release, `take`=1 and `take_code`=2'b01. `cpsr_out` has mode 5'b10011, A/I/F set, T/J clear, E equal to `endian_init` and all other bits 0. `ns_out`=0, `vec_off`=0 and `link_addr`=0. This entry takes precedence over interrupts.
- R8: On interrupt entry, `link_addr` = `next_pc` + 4 and `spsr_out` = `cpsr_in`, both sampled at the boundary edge.
- R9: `take` is high for exactly one cycle per entry. The code is 2'b10 for fast and 2'b11 for normal. `vec_off` is 5'h1C for fast and 5'h18 for normal. Outputs hold between entries.
- R10: `ns_out` is 0 on entry to monitor mode and equals `ns_in` on any other interrupt entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_n | input | 1 | Fast interrupt request, active low |
| irq_n | input | 1 | Normal interrupt request, active low |
| boundary | input | 1 | Instruction-boundary strobe |
| cpsr_in | input | 32 | Current status word |
| ns_in | input | 1 | Current world, 1 = non-secure |
| cfg_fw | input | 1 | Fast interrupt unmaskable in non-secure world |
| cfg_fiq_mon | input | 1 | Route fast interrupt to monitor mode |
| cfg_irq_mon | input | 1 | Route normal interrupt to monitor mode |
| endian_init | input | 1 | Reset value of the E bit |
| next_pc | input | ADDR_W | Address of the next instruction |
| take | output | 1 | One-cycle entry pulse |
| take_code | output | 2 | 00 none, 01 reset, 10 fast, 11 normal |
| cpsr_out | output | 32 | New status word |
| spsr_out | output | 32 | Previous status word to save |
| link_addr | output | ADDR_W | Link register value |
| vec_off | output | 5 | Vector offset |
| vec_mon | output | 1 | Use monitor vector table |
| ns_out | output | 1 | World after entry |

## Verification
The bench presents both requests at the same boundary. A design with the priority reversed would enter normal mode, or would set only I. It lowers a line in the very cycle of the strobe, which exposes a design that reads the raw pin rather than the registered one.

It sweeps `ns_in` and `cfg_fw` with F set. A design that ignores the override would lose the fast interrupt, and one that applies it too widely would take it in the secure world. It also checks monitor routing for both lines and the exact reset word, including E. Errors here show up as a wrong mode, a missing world change or an off-by-one link value.

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_n,
  input  logic              irq_n,
  input  logic              boundary,
  input  logic [31:0]       cpsr_in,
  input  logic              ns_in,
  input  logic              cfg_fw,
  input  logic              cfg_fiq_mon,
  input  logic              cfg_irq_mon,
  input  logic              endian_init,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              take,
  output logic [1:0]        take_code,
  output logic [31:0]       cpsr_out,
  output logic [31:0]       spsr_out,
  output logic [ADDR_W-1:0] link_addr,
  output logic [4:0]        vec_off,
  output logic              vec_mon,
  output logic              ns_out
);
  localparam int T_B = 5, F_B = 6, I_B = 7, A_B = 8, E_B = 9, J_B = 24;
  localparam logic [4:0] M_FIQ = 5'b10001, M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011, M_MON = 5'b10110;
  localparam logic [1:0] C_RST = 2'b01, C_FIQ = 2'b10, C_IRQ = 2'b11;

  logic fiq_q, irq_q, rst_pend;
  logic [31:0] entry_psr, reset_psr;

  wire fiq_req = !fiq_q && (!cpsr_in[F_B] || (ns_in && cfg_fw));
  wire irq_req = !irq_q && !cpsr_in[I_B];
  wire do_fiq  = boundary && fiq_req;
  wire do_irq  = boundary && irq_req && !fiq_req;
  wire to_mon  = do_fiq ? cfg_fiq_mon : cfg_irq_mon;

  always_comb begin
    entry_psr = cpsr_in;
    entry_psr[4:0] = to_mon ? M_MON : (do_fiq ? M_FIQ : M_IRQ);
    entry_psr[T_B] = 1'b0;
    entry_psr[J_B] = 1'b0;
    entry_psr[I_B] = 1'b1;
    if (do_fiq) entry_psr[F_B] = 1'b1;
    reset_psr = 32'd0;
    reset_psr[4:0] = M_SVC;
    reset_psr[A_B] = 1'b1;
    reset_psr[I_B] = 1'b1;
    reset_psr[F_B] = 1'b1;
    reset_psr[E_B] = endian_init;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_q <= 1'b1;
      irq_q <= 1'b1;
      rst_pend <= 1'b1;
      take <= 1'b0;
      take_code <= 2'b00;
      cpsr_out <= 32'd0;
      spsr_out <= 32'd0;
      link_addr <= '0;
      vec_off <= 5'd0;
      vec_mon <= 1'b0;
      ns_out <= 1'b0;
    end else begin
      fiq_q <= fiq_n;
      irq_q <= irq_n;
      take <= 1'b0;
      if (rst_pend) begin
        rst_pend <= 1'b0;
        take <= 1'b1;
        take_code <= C_RST;
        cpsr_out <= reset_psr;
        spsr_out <= 32'd0;
        link_addr <= '0;
        vec_off <= 5'h00;
        vec_mon <= 1'b0;
        ns_out <= 1'b0;
      end else if (do_fiq || do_irq) begin
        take <= 1'b1;
        take_code <= do_fiq ? C_FIQ : C_IRQ;
        cpsr_out <= entry_psr;
        spsr_out <= cpsr_in;
        link_addr <= next_pc + ADDR_W'(4);
        vec_off <= do_fiq ? 5'h1C : 5'h18;
        vec_mon <= to_mon;
        ns_out <= to_mon ? 1'b0 : ns_in;
      end
    end
  end
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic [ADDR_W-1:0] next_pc,
  input logic              take,
  input logic [1:0]        take_code,
  input logic [31:0]       cpsr_out,
  input logic [ADDR_W-1:0] link_addr,
  input logic              vec_mon,
  input logic              ns_out
);
  assert_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code[1]) |-> $past(boundary));

  assert_code_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_code != 2'b00));

  assert_fast_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 2'b10) |-> (cpsr_out[6] && cpsr_out[7] && !cpsr_out[5] && !cpsr_out[24]));

  assert_normal_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 2'b11) |-> (cpsr_out[7] && !cpsr_out[5] && !cpsr_out[24]));

  assert_fast_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 2'b10) |-> (cpsr_out[4:0] == (vec_mon ? 5'b10110 : 5'b10001)));

  assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 2'b01) |-> (cpsr_out[4:0] == 5'b10011 && !ns_out && cpsr_out[8:6] == 3'b111));

  assert_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code[1]) |-> (link_addr == $past(next_pc) + ADDR_W'(4)));

  assert_monitor_secure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_mon) |-> !ns_out);
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .next_pc(next_pc),
  .take(take), .take_code(take_code), .cpsr_out(cpsr_out),
  .link_addr(link_addr), .vec_mon(vec_mon), .ns_out(ns_out)
);

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;
  logic clk = 0, rst_n = 0, fiq_n = 1, irq_n = 1, boundary = 0;
  logic [31:0] cpsr_in = 32'h0000_0010;
  logic ns_in = 0, cfg_fw = 0, cfg_fiq_mon = 0, cfg_irq_mon = 0, endian_init = 1;
  logic [31:0] next_pc = 32'h0000_1000;
  logic take, vec_mon, ns_out;
  logic [1:0] take_code;
  logic [31:0] cpsr_out, spsr_out, link_addr;
  logic [4:0] vec_off;
  int checks = 0, errors = 0;
  string tag = "R9";

  always #10 clk = ~clk;

  irq_entry_ctrl #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .fiq_n(fiq_n), .irq_n(irq_n), .boundary(boundary),
    .cpsr_in(cpsr_in), .ns_in(ns_in), .cfg_fw(cfg_fw), .cfg_fiq_mon(cfg_fiq_mon),
    .cfg_irq_mon(cfg_irq_mon), .endian_init(endian_init), .next_pc(next_pc),
    .take(take), .take_code(take_code), .cpsr_out(cpsr_out), .spsr_out(spsr_out),
    .link_addr(link_addr), .vec_off(vec_off), .vec_mon(vec_mon), .ns_out(ns_out));

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // behavioural reference model
  logic m_fs = 1, m_is = 1, m_rp = 1, e_take = 0, e_mon = 0, e_ns = 0;
  logic [1:0] e_code = 0;
  logic [31:0] e_cpsr = 0, e_spsr = 0, e_link = 0;
  logic [4:0] e_vec = 0;
  always @(posedge clk) begin
    logic f_ok, i_ok, mon;
    if (!rst_n) begin
      m_fs = 1; m_is = 1; m_rp = 1; e_take = 0; e_code = 0; e_cpsr = 0;
      e_spsr = 0; e_link = 0; e_vec = 0; e_mon = 0; e_ns = 0;
    end else begin
      f_ok = boundary && !m_fs && (!cpsr_in[6] || (ns_in && cfg_fw));
      i_ok = boundary && !m_is && !cpsr_in[7] && !f_ok;
      e_take = 0;
      if (m_rp) begin
        m_rp = 0; e_take = 1; e_code = 2'b01;
        e_cpsr = 32'h1D3 | (32'(endian_init) << 9);
        e_spsr = 0; e_link = 0; e_vec = 0; e_mon = 0; e_ns = 0;
      end else if (f_ok || i_ok) begin
        mon = f_ok ? cfg_fiq_mon : cfg_irq_mon;
        e_take = 1; e_code = f_ok ? 2'b10 : 2'b11;
        e_cpsr = cpsr_in & ~32'h0100_003F;
        e_cpsr = e_cpsr | 32'h80 | (f_ok ? 32'h40 : 32'h0);
        e_cpsr = e_cpsr | (mon ? 32'h16 : (f_ok ? 32'h11 : 32'h12));
        e_spsr = cpsr_in; e_link = next_pc + 4;
        e_vec = f_ok ? 5'h1C : 5'h18; e_mon = mon; e_ns = mon ? 1'b0 : ns_in;
      end
      m_fs = fiq_n; m_is = irq_n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check({tag, " take"}, 32'(take), 32'(e_take));
    check({tag, " code"}, 32'(take_code), 32'(e_code));
    check({tag, " cpsr"}, cpsr_out, e_cpsr);
    check({tag, " spsr"}, spsr_out, e_spsr);
    check({tag, " link"}, link_addr, e_link);
    check({tag, " vec"}, 32'(vec_off), 32'(e_vec));
    check({tag, " mon/ns"}, {30'd0, vec_mon, ns_out}, {30'd0, e_mon, e_ns});
  end

  task automatic entry(input logic f_n, input logic i_n);
    fiq_n = f_n; irq_n = i_n;
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0; fiq_n = 1; irq_n = 1;
  endtask

  task automatic idle(); @(negedge clk); @(negedge clk); endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    check("R7 reset take", 32'(take), 32'd0);
    repeat (2) @(negedge clk);
    tag = "R7"; rst_n = 1;
    @(negedge clk);
    check("R7 reset code", {31'd0, take, take_code}, {31'd0, 1'b1, 2'b01});
    check("R7 reset word", cpsr_out, 32'h0000_03D3);
    check("R7 reset ns/vec", {26'd0, ns_out, vec_off}, 32'd0);
    @(negedge clk);
    check("R9 single pulse", 32'(take), 32'd0);

    tag = "R2"; cpsr_in = 32'h0000_00D0;
    entry(0, 0);
    check("R2 masked", 32'(take), 32'd0);
    cpsr_in = 32'h0000_0010; fiq_n = 0;
    idle();
    check("R2 no strobe", 32'(take), 32'd0);
    fiq_n = 1; idle();

    tag = "R1"; irq_n = 0; boundary = 1;
    @(negedge clk); boundary = 0; irq_n = 1;
    check("R1 raw line ignored", 32'(take), 32'd0);
    idle();

    tag = "R3"; next_pc = 32'h0000_2000;
    entry(0, 0);
    check("R3 fast wins", 32'(take_code), 32'd2);
    check("R4 fast masks", cpsr_out, 32'h0000_00D1);
    check("R9 fast vector", 32'(vec_off), 32'h1C);
    check("R8 fast link", link_addr, 32'h0000_2004);
    idle();

    tag = "R4"; cpsr_in = 32'h8100_0130; next_pc = 32'h0000_3000;
    entry(1, 0);
    check("R4 normal word", cpsr_out, 32'h8000_0192);
    check("R8 saved word", spsr_out, 32'h8100_0130);
    check("R8 normal link", link_addr, 32'h0000_3004);
    check("R9 normal vector", 32'(vec_off), 32'h18);
    idle();

    tag = "R5"; cpsr_in = 32'h0000_0050; ns_in = 1; cfg_fw = 1;
    entry(0, 1);
    check("R5 override taken", {31'd0, take, take_code}, {31'd0, 1'b1, 2'b10});
    check("R10 ns kept", 32'(ns_out), 32'd1);
    idle();
    ns_in = 0;
    entry(0, 1);
    check("R5 secure masked", 32'(take), 32'd0);
    idle();
    ns_in = 1; cfg_fw = 0;
    entry(0, 1);
    check("R5 no override masked", 32'(take), 32'd0);
    idle();

    tag = "R6"; cpsr_in = 32'h0000_0010; cfg_fiq_mon = 1;
    entry(0, 1);
    check("R6 fast to monitor", {26'd0, vec_mon, cpsr_out[4:0]}, {26'd0, 1'b1, 5'b10110});
    check("R10 monitor secure", 32'(ns_out), 32'd0);
    idle();
    cfg_fiq_mon = 0; cfg_irq_mon = 1;
    entry(1, 0);
    check("R6 normal to monitor", {26'd0, vec_mon, cpsr_out[4:0]}, {26'd0, 1'b1, 5'b10110});
    idle();
    cfg_irq_mon = 0;
    entry(1, 0);
    check("R6 normal own mode", {26'd0, vec_mon, cpsr_out[4:0]}, {26'd0, 1'b0, 5'b10010});
    check("R10 ns follows", 32'(ns_out), 32'd1);
    idle();

    tag = "R7"; rst_n = 0; endian_init = 0; fiq_n = 0; cpsr_in = 32'h0;
    @(negedge clk); rst_n = 1; boundary = 1;
    @(negedge clk); boundary = 0; fiq_n = 1;
    check("R7 reset precedes", 32'(take_code), 32'd1);
    check("R7 reset E clear", cpsr_out, 32'h0000_01D3);
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule